// File: doc/BRIEF.md
# Ethernet Controller Sleep/Wake Sequencer

This block runs on the host side of an Ethernet controller and walks it into and out of its low-power sleep state. It never touches the serial link itself. Instead it sends register commands to a separate command engine and takes back one response for each command. Commands are single-bit set, single-bit clear or register read. A read is used to poll a status or control bit until that bit reaches the wanted level.

A one-cycle pulse on `sleep_req` starts the entry procedure. The sequencer turns receive off, waits for the receive path to drain, then waits for any pending transmit to drain. Only then does it turn on the regulator power-save bit, and after that the sleep bit. A pulse on `wake_req` starts the exit procedure. The sequencer clears the sleep bit, waits until a minimum stabilisation time has passed and the clock-ready flag reads set, and then turns receive back on as its final step.

Each poll loop has a time limit. When the limit runs out, the sequencer abandons the procedure, returns to idle and raises `timeout_err`.

The command channel uses valid/ready. The sequencer holds `cmd_valid` and the command fields steady until `cmd_ready` is seen high at a clock edge. Once a command is accepted, it issues nothing further until the matching response arrives. The response channel has no ready signal: the engine raises `rsp_valid` for exactly one cycle for each accepted command, and the sequencer always takes it.

Top module: `eth_pwr_seq`

## Requirements
- R1: After reset the outputs are `busy`=0, `done`=0, `timeout_err`=0, `asleep`=0 and `cmd_valid`=0.
- R2: Sleep entry issues its writes in this order: clear control-1 bit 2 (receive enable), set control-2 bit 3 (regulator power save), set control-2 bit 5 (sleep). Op codes are 0 for read, 1 for bit-set and 2 for bit-clear.
- R3: After receive is disabled, the status register is read repeatedly. The sequence does not move on until status bit 2 (receive busy) reads 0. Exactly one extra read follows the last busy read.
- R4: Next, control-1 is read repeatedly until bit 3 (transmit request) reads 0. Nothing is written to control-2 before both drains have completed.
- R5: Wake issues exactly two writes: clear control-2 bit 5, then set control-1 bit 2. Setting receive enable is always the last step.
- R6: The receive-enable set command is not accepted until at least STAB_CYC cycles after the sleep-clear command was accepted. STAB_CYC is CLK_HZ·STAB_US/10⁶, rounded up.
- R7: The receive-enable set command is not accepted until a read of status bit 0 (clock ready) has returned 1.
- R8: If a poll still mismatches once TMO_CYC cycles have passed since the poll step began, the sequencer returns to idle and sets `timeout_err`. For the clock-ready poll, this window starts when the minimum delay expires. No further commands are issued, and `asleep` keeps its value.
- R9: A sleep request is ignored while `asleep`=1, a wake request is ignored while `asleep`=0, and both are ignored while `busy`=1.
- R10: Every write command carries a mask with exactly one bit set. Every other bit of the target register is left unchanged.
- R11: While `cmd_valid`=1 and `cmd_ready`=0, the command fields stay stable.
- R12: A successful procedure raises `done` for one cycle and sets `asleep` to 1 after sleep, or 0 after wake. `timeout_err` clears when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Pulse that starts sleep entry |
| wake_req | input | 1 | Pulse that starts wake |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 read, 1 bit-set, 2 bit-clear |
| cmd_addr | output | ADDR_W | Register address |
| cmd_mask | output | DATA_W | Single-bit mask for the operation |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_data | input | DATA_W | Read data (ignored for writes) |
| busy | output | 1 | A procedure is in progress |
| done | output | 1 | One-cycle pulse when a procedure completes |
| timeout_err | output | 1 | Last procedure aborted on a poll timeout |
| asleep | output | 1 | The controller is in sleep |

## Verification
The bench holds receive-busy and transmit-request set across several polls. A sequencer that advanced on the first read would write control-2 while traffic was still draining, and the engine model flags that write. On wake, clock-ready is reported early in one case, so a design that skipped the minimum delay would turn receive back on too soon. In another case clock-ready arrives after the delay, which catches a design that trusted the delay alone. A stuck busy bit and a clock-ready flag that never sets must both end in an abort that leaves `asleep` unchanged. Requests in the wrong state, and requests made while busy, must issue no commands. The command engine model stalls `cmd_ready` to exercise the hold rule.

// File: rtl/eth_pwr_seq_pkg.sv
package eth_pwr_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } seq_op_e;

  typedef enum logic {
    MODE_SLEEP = 1'b0,
    MODE_WAKE  = 1'b1
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam int STEP_W = 3;
endpackage

// File: rtl/eth_pwr_seq_cnt.sv
module eth_pwr_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (!zero)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // Once expired, the count stays expired until it is reloaded (R6, R8)
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/eth_pwr_seq_steps.sv
module eth_pwr_seq_steps
  import eth_pwr_seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_CTL1 = 5'h1F,
  parameter logic [ADDR_W-1:0] A_CTL2 = 5'h1E,
  parameter logic [ADDR_W-1:0] A_STAT = 5'h1D,
  parameter int B_RXEN   = 2,
  parameter int B_TXREQ  = 3,
  parameter int B_RXBUSY = 2,
  parameter int B_CLKRDY = 0,
  parameter int B_VREG   = 3,
  parameter int B_SLEEP  = 5
) (
  input  seq_mode_e         mode,
  input  logic [STEP_W-1:0] idx,
  output seq_op_e           op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] mask,
  output logic              want,
  output logic              gated,
  output logic              last
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    op    = OP_READ;
    addr  = A_STAT;
    mask  = ONE;
    want  = 1'b0;
    gated = 1'b0;
    last  = 1'b0;
    if (mode == MODE_SLEEP) begin
      case (idx)
        3'd0: begin op = OP_CLR;  addr = A_CTL1; mask = ONE << B_RXEN;   end
        3'd1: begin op = OP_READ; addr = A_STAT; mask = ONE << B_RXBUSY; end
        3'd2: begin op = OP_READ; addr = A_CTL1; mask = ONE << B_TXREQ;  end
        3'd3: begin op = OP_SET;  addr = A_CTL2; mask = ONE << B_VREG;   end
        default: begin op = OP_SET; addr = A_CTL2; mask = ONE << B_SLEEP; last = 1'b1; end
      endcase
    end else begin
      case (idx)
        3'd0: begin op = OP_CLR;  addr = A_CTL2; mask = ONE << B_SLEEP; end
        3'd1: begin
          op = OP_READ; addr = A_STAT; mask = ONE << B_CLKRDY;
          want = 1'b1; gated = 1'b1;
        end
        default: begin op = OP_SET; addr = A_CTL1; mask = ONE << B_RXEN; last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/eth_pwr_seq.sv
module eth_pwr_seq
  import eth_pwr_seq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 8,
  parameter int CLK_HZ  = 50_000_000,
  parameter int STAB_US = 300,
  parameter int TMO_CYC = 65_535,
  parameter logic [ADDR_W-1:0] A_CTL1 = 5'h1F,
  parameter logic [ADDR_W-1:0] A_CTL2 = 5'h1E,
  parameter logic [ADDR_W-1:0] A_STAT = 5'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_req,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_mask,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic              asleep
);
  localparam longint STAB_L   = (longint'(CLK_HZ) * STAB_US + 64'd999_999) / 64'd1_000_000;
  localparam int     STAB_CYC = int'(STAB_L);
  localparam int     DW       = $clog2(STAB_CYC + 1);
  localparam int     TW       = $clog2(TMO_CYC + 1);

  seq_state_e        state;
  seq_mode_e         mode;
  logic [STEP_W-1:0] idx;

  seq_op_e           s_op;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_mask;
  logic              s_want, s_gated, s_last;

  logic dly_zero, tmo_zero, dly_load, tmo_load;
  logic start_sleep, start_wake, start;
  logic is_poll, hit, step_ok, advance;

  eth_pwr_seq_steps #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_CTL1(A_CTL1), .A_CTL2(A_CTL2), .A_STAT(A_STAT)
  ) u_steps (
    .mode(mode), .idx(idx), .op(s_op), .addr(s_addr), .mask(s_mask),
    .want(s_want), .gated(s_gated), .last(s_last)
  );

  assign start_sleep = (state == ST_IDLE) && !asleep && sleep_req;
  assign start_wake  = (state == ST_IDLE) && asleep && wake_req;
  assign start       = start_sleep || start_wake;

  assign is_poll = (s_op == OP_READ);
  assign hit     = (((rsp_data & s_mask) != '0) == s_want);
  assign step_ok = !is_poll || (hit && (!s_gated || dly_zero));
  assign advance = (state == ST_WAIT) && rsp_valid && step_ok;

  // The stabilisation delay starts once the sleep bit has been cleared
  assign dly_load = (state == ST_WAIT) && rsp_valid && (mode == MODE_WAKE) && (idx == '0);
  // The poll window reopens for each step and is held off while the delay runs
  assign tmo_load = start || advance || ((state != ST_IDLE) && s_gated && !dly_zero);

  eth_pwr_seq_cnt #(.W(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load),
    .load_val(DW'(STAB_CYC)), .zero(dly_zero)
  );

  eth_pwr_seq_cnt #(.W(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(tmo_load),
    .load_val(TW'(TMO_CYC)), .zero(tmo_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mode        <= MODE_SLEEP;
      idx         <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      asleep      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mode        <= start_wake ? MODE_WAKE : MODE_SLEEP;
          idx         <= '0;
          timeout_err <= 1'b0;
          state       <= ST_ISSUE;
        end
        ST_ISSUE: if (cmd_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          if (step_ok) begin
            if (s_last) begin
              state  <= ST_IDLE;
              done   <= 1'b1;
              asleep <= (mode == MODE_SLEEP);
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_ISSUE;
            end
          end else if (tmo_zero) begin
            state       <= ST_IDLE;
            timeout_err <= 1'b1;
          end else begin
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign cmd_valid = (state == ST_ISSUE);
  assign cmd_op    = s_op;
  assign cmd_addr  = s_addr;
  assign cmd_mask  = s_mask;

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_mask)));

  p_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($countones(cmd_mask) == 1));

  p_rxen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET && cmd_addr == A_CTL1) |-> dly_zero);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!busy && !cmd_valid && $stable(asleep)));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !timeout_err));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && asleep && !wake_req) |=> !busy);
endmodule

// File: tb/sim_eth_pwr_seq.sv
module sim_eth_pwr_seq;
  localparam int PERIOD = 10;
  localparam int STAB   = 20;
  localparam int TMO    = 40;
  localparam logic [4:0] C1 = 5'h1F, C2 = 5'h1E, ST = 5'h1D;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [1:0] cmd_op;
  logic [4:0] cmd_addr;
  logic [7:0] cmd_mask;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic busy, done, timeout_err, asleep;

  eth_pwr_seq #(.CLK_HZ(1_000_000), .STAB_US(STAB), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_mask(cmd_mask), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done),
    .timeout_err(timeout_err), .asleep(asleep)
  );

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // controller model state
  logic [7:0] ctl1 = 8'h8F, ctl2 = 8'h80;
  int rx_left = 0, tx_left = 0, rdy_at = 0;
  int n_wr = 0, n_stat_rd = 0, n_c1_rd = 0, n_done = 0;
  int t_clr = 0, t_set = 0;
  bit order_bad = 0, stall = 0;
  logic [1:0] w_op [0:63];
  logic [4:0] w_addr [0:63];
  logic [7:0] w_mask [0:63];

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // command engine and register model
  initial begin
    int pend = 0;
    logic [7:0] q = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        cmd_ready = 1'b0;
        if (pend == 0) begin rsp_valid = 1'b1; rsp_data = q; end
      end else begin
        cmd_ready = stall ? (cyc % 3 != 0) : 1'b1;
        if (cmd_valid && cmd_ready) begin
          pend = 2;
          q = '0;
          if (cmd_op == 2'd0) begin
            if (cmd_addr == ST) begin
              n_stat_rd++;
              q = 8'h80 | ((rx_left > 0) ? 8'h04 : 8'h00) |
                  ((!ctl2[5] && cyc >= rdy_at) ? 8'h01 : 8'h00);
              if (rx_left > 0) rx_left--;
            end else if (cmd_addr == C1) begin
              n_c1_rd++;
              if (tx_left == 0) ctl1[3] = 1'b0; else tx_left--;
              q = ctl1;
            end
          end else begin
            w_op[n_wr % 64] = cmd_op; w_addr[n_wr % 64] = cmd_addr; w_mask[n_wr % 64] = cmd_mask;
            n_wr++;
            if (cmd_addr == C2 && (rx_left > 0 || ctl1[3])) order_bad = 1;
            if (cmd_addr == C2 && cmd_op == 2'd1 && cmd_mask == 8'h20 && !ctl2[3]) order_bad = 1;
            if (cmd_addr == C2 && cmd_op == 2'd2) t_clr = cyc;
            if (cmd_addr == C1 && cmd_op == 2'd1) begin
              t_set = cyc;
              if (ctl2[5]) order_bad = 1;
            end
            if (cmd_addr == C1) ctl1 = (cmd_op == 2'd1) ? (ctl1 | cmd_mask) : (ctl1 & ~cmd_mask);
            if (cmd_addr == C2) ctl2 = (cmd_op == 2'd1) ? (ctl2 | cmd_mask) : (ctl2 & ~cmd_mask);
          end
        end
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) n_done++;
  end

  task automatic pulse(input bit wake);
    @(negedge clk);
    if (wake) wake_req = 1'b1; else sleep_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0; sleep_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", timeout_err, 0);
    chk("R1 asleep", asleep, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
  endtask

  task automatic t_wake_while_awake();
    int w0 = n_wr;
    pulse(1);
    chk("R9 wake ignored busy", busy, 0);
    repeat (10) @(negedge clk);
    chk("R9 wake ignored no cmd", n_wr - w0, 0);
    chk("R9 wake ignored asleep", asleep, 0);
  endtask

  task automatic t_sleep_timeout();
    int w0 = n_wr;
    rx_left = 100000; tx_left = 0;
    pulse(0);
    chk("R8 started", busy, 1);
    wait_idle();
    chk("R8 err set", timeout_err, 1);
    chk("R8 asleep kept", asleep, 0);
    chk("R8 only rx clear written", n_wr - w0, 1);
    chk("R8 ctl2 untouched", ctl2, 8'h80);
    repeat (10) @(negedge clk);
    chk("R8 no further cmds", n_wr - w0, 1);
  endtask

  task automatic t_sleep_full();
    int w0 = n_wr, s0, c0, d0 = n_done;
    rx_left = 3; tx_left = 2; ctl1 = 8'h8F; ctl2 = 8'h80; order_bad = 0; stall = 1;
    s0 = n_stat_rd; c0 = n_c1_rd;
    pulse(0);
    chk("R12 err cleared on accept", timeout_err, 0);
    pulse(1); pulse(0);  // requests during busy
    wait_idle();
    stall = 0;
    chk("R2 write count", n_wr - w0, 3);
    chk("R2 w0 op", w_op[w0 % 64], 2); chk("R2 w0 addr", w_addr[w0 % 64], C1); chk("R2 w0 mask", w_mask[w0 % 64], 8'h04);
    chk("R2 w1 op", w_op[(w0+1) % 64], 1); chk("R2 w1 addr", w_addr[(w0+1) % 64], C2); chk("R2 w1 mask", w_mask[(w0+1) % 64], 8'h08);
    chk("R2 w2 op", w_op[(w0+2) % 64], 1); chk("R2 w2 addr", w_addr[(w0+2) % 64], C2); chk("R2 w2 mask", w_mask[(w0+2) % 64], 8'h20);
    chk("R3 status reads", n_stat_rd - s0, 4);
    chk("R4 ctl1 reads", n_c1_rd - c0, 3);
    chk("R4 no early ctl2 write", order_bad, 0);
    chk("R10 ctl1 others kept", ctl1, 8'h83);
    chk("R10 ctl2 others kept", ctl2, 8'hA8);
    chk("R12 asleep", asleep, 1);
    chk("R9 R12 one done", n_done - d0, 1);
  endtask

  task automatic t_sleep_while_asleep();
    int w0 = n_wr;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R9 sleep ignored", n_wr - w0 + int'(busy), 0);
    chk("R9 still asleep", asleep, 1);
  endtask

  task automatic t_quick_sleep();
    rx_left = 0; tx_left = 0; ctl1[3] = 1'b0;
    pulse(0);
    wait_idle();
    chk("R12 asleep again", asleep, 1);
  endtask

  task automatic t_wake(input int rdy_delay, input bit expect_ok);
    int w0 = n_wr, d0 = n_done;
    order_bad = 0;
    rdy_at = cyc + rdy_delay;
    pulse(1);
    wait_idle();
    if (expect_ok) begin
      chk("R5 writes", n_wr - w0, 2);
      chk("R5 first clears sleep", {w_op[w0 % 64], w_addr[w0 % 64], w_mask[w0 % 64]}, {2'd2, C2, 8'h20});
      chk("R5 last sets rxen", {w_op[(w0+1) % 64], w_addr[(w0+1) % 64], w_mask[(w0+1) % 64]}, {2'd1, C1, 8'h04});
      chk("R6 min delay", int'((t_set - t_clr) >= STAB), 1);
      chk("R7 after clock ready", int'(t_set >= rdy_at), 1);
      chk("R10 vreg kept", ctl2, 8'h88);
      chk("R10 ctl1 rxen only", ctl1, 8'h87);
      chk("R12 awake", asleep, 0);
      chk("R12 done", n_done - d0, 1);
      chk("R5 order", order_bad, 0);
    end else begin
      chk("R8 wake err", timeout_err, 1);
      chk("R8 wake asleep kept", asleep, 1);
      chk("R8 rxen not set", ctl1[2], 0);
      chk("R8 one write", n_wr - w0, 1);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wake_while_awake();
    t_sleep_timeout();
    t_sleep_full();
    t_sleep_while_asleep();
    t_wake(0, 1);           // clock ready early: delay must gate
    ctl1[3] = 1'b0;
    t_quick_sleep();
    ctl2[5] = 1'b1;
    t_wake(STAB + 30, 1);   // clock ready after the delay
    t_quick_sleep();
    t_wake(1000000, 0);     // clock ready never sets
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule